// File: doc/BRIEF.md
# Sticky Status Interrupt Logic

This block watches three live comparator levels of a battery-powered supply controller: battery absent, 3.3 V rail out of regulation, and charger present. Each level is brought into the clock domain through a flop chain, masked by an enable that comes from the operating-mode logic, and registered as a status bit. A sticky interrupt flag sits beside each status bit. The battery and charger flags latch on any change of their masked level. The rail flag latches only when the rail goes out of regulation.

The flags are cleared by write-one strobes from the serial interface. A set event and a clear strobe in the same cycle leave the flag set. The interrupt line is high while any flag is set. The six bits are offered to the serial shifter as one vector, with the first bit to be shifted out at the top. At power-on reset the battery flag and the charger flag take opposite values that depend on whether a charger is seen at that moment.

Top module: `stat_irq_core`

## Requirements
- R1: The battery flag (status_bits[5]) is set on every change of the masked battery level (status_bits[4]), rising or falling.
- R2: The rail flag (status_bits[3]) is set when the masked rail level (status_bits[2]) goes from 0 to 1. A change from 1 to 0 does not set it.
- R3: The charger flag (status_bits[1]) is set on every change of the masked charger level (status_bits[0]), rising or falling.
- R4: A channel whose enable bit is 0 reports level 0, whatever its raw input. The change of level caused only by toggling the enable counts as a change for R1 to R3, and it appears one clock edge after the enable changes.
- R5: irq is 1 exactly when at least one of the three flags is 1. irq can only fall after a clear strobe.
- R6: The status vector is ordered battery flag [5], battery level [4], rail flag [3], rail level [2], charger flag [1], charger level [0]. In cmp_raw, cmp_en and flag_clr, bit 0 is the battery channel, bit 1 is the rail channel and bit 2 is the charger channel.
- R7: While rst is high, every level bit reads 0 and the rail flag is 0. The battery flag is the inverse of cmp_raw[2] and the charger flag equals cmp_raw[2].
- R8: A 1 on a flag_clr bit clears that channel's flag at the next clock edge. A 0 bit leaves its flag unchanged.
- R9: If a set event and a clear strobe for the same flag fall in the same cycle, the flag remains set.
- R10: With the default two synchroniser stages, a change on cmp_raw reaches status_bits at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmp_raw | input | 3 | Raw comparator levels, asynchronous to clk |
| cmp_en | input | 3 | Comparator enables from the mode logic, synchronous to clk |
| flag_clr | input | 3 | Write-one clear strobes for the flags, one cycle wide |
| status_bits | output | 6 | Flag and level pairs, battery first |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
Each channel has its raw level driven up and then down. This separates the rule that latches on both edges (battery, charger) from the rule that latches on the rising edge only (rail). A raw level that is already present is then enabled and disabled. This shows that masking alone produces a change that sets the flags. Clear strobes are placed in the exact cycle of a set event and also on other channels, to cover the priority of set over clear and the independence of the clear bits. Several flags are raised at once and cleared one at a time, to show that irq follows the OR of the flags. Reset is applied with and without a charger present, to check both power-up presets.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

    localparam int NUM_SRC  = 3;
    localparam int SRC_BATT = 0;
    localparam int SRC_RAIL = 1;
    localparam int SRC_CHG  = 2;
    localparam int STAT_W   = 2 * NUM_SRC;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_rule_e;

    typedef struct packed {
        logic flag;
        logic level;
    } chan_state_t;

    // The rail channel latches only when the rail leaves regulation.
    function automatic edge_rule_e rule_of(input int idx);
        return (idx == SRC_RAIL) ? EDGE_RISE : EDGE_ANY;
    endfunction

    function automatic logic edge_hit(input edge_rule_e rule,
                                      input logic now_lvl,
                                      input logic old_lvl);
        if (rule == EDGE_RISE)
            return now_lvl & ~old_lvl;
        return now_lvl ^ old_lvl;
    endfunction

    // Battery channel lands in the top pair, because it is shifted out first.
    function automatic logic [STAT_W-1:0] pack_status(
        input chan_state_t [NUM_SRC-1:0] ch);
        logic [STAT_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            v[STAT_W-1-2*i] = ch[i].flag;
            v[STAT_W-2-2*i] = ch[i].level;
        end
        return v;
    endfunction

endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/stat_chan.sv
module stat_chan
    import stat_irq_pkg::*;
#(
    parameter edge_rule_e RULE = EDGE_ANY
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl_sync,
    input  logic        enable,
    input  logic        clr,
    input  logic        por_flag,
    output chan_state_t state
);
    logic masked;
    logic hit;

    assign masked = lvl_sync & enable;
    assign hit    = edge_hit(RULE, masked, state.level);

    always_ff @(posedge clk) begin
        if (rst) begin
            state.level <= 1'b0;
            state.flag  <= por_flag;
        end else begin
            state.level <= masked;
            // A set event takes priority over a clear strobe.
            state.flag  <= hit | (state.flag & ~clr);
        end
    end
endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge
    import stat_irq_pkg::*;
(
    input  chan_state_t [NUM_SRC-1:0] ch,
    output logic [STAT_W-1:0]         status_bits,
    output logic                      irq
);
    always_comb begin
        status_bits = pack_status(ch);
        irq = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
            irq = irq | ch[i].flag;
    end
endmodule

// File: rtl/stat_irq_core.sv
module stat_irq_core
    import stat_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] cmp_raw,
    input  logic [NUM_SRC-1:0] cmp_en,
    input  logic [NUM_SRC-1:0] flag_clr,
    output logic [STAT_W-1:0]  status_bits,
    output logic               irq
);
    logic [NUM_SRC-1:0]        lvl_sync;
    logic [NUM_SRC-1:0]        por_flags;
    chan_state_t [NUM_SRC-1:0] ch;

    stat_sync #(
        .WIDTH (NUM_SRC),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(cmp_raw),
        .q_sync (lvl_sync)
    );

    // Power-up presets: the battery flag is set without a charger, and the charger flag is set with one.
    always_comb begin
        por_flags           = '0;
        por_flags[SRC_BATT] = ~cmp_raw[SRC_CHG];
        por_flags[SRC_CHG]  =  cmp_raw[SRC_CHG];
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_chan
            stat_chan #(
                .RULE(rule_of(i))
            ) u_chan (
                .clk     (clk),
                .rst     (rst),
                .lvl_sync(lvl_sync[i]),
                .enable  (cmp_en[i]),
                .clr     (flag_clr[i]),
                .por_flag(por_flags[i]),
                .state   (ch[i])
            );
        end
    endgenerate

    stat_irq_merge u_merge (
        .ch         (ch),
        .status_bits(status_bits),
        .irq        (irq)
    );
endmodule

// File: rtl/stat_irq_core_chk.sv
module stat_irq_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] cmp_en,
    input logic [2:0] flag_clr,
    input logic [5:0] status_bits,
    input logic       irq
);
    a_r1_batt_change_sets: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_bits[4]) |-> status_bits[5]);

    a_r2_rail_rise_sets: assert property (@(posedge clk) disable iff (rst)
        $rose(status_bits[2]) |-> status_bits[3]);

    a_r2_rail_fall_quiet: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_bits[2]) && !$past(status_bits[3])) |-> !status_bits[3]);

    a_r3_chg_change_sets: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_bits[0]) |-> status_bits[1]);

    a_r4_batt_masked: assert property (@(posedge clk) disable iff (rst)
        !cmp_en[0] |=> !status_bits[4]);

    a_r4_rail_masked: assert property (@(posedge clk) disable iff (rst)
        !cmp_en[1] |=> !status_bits[2]);

    a_r4_chg_masked: assert property (@(posedge clk) disable iff (rst)
        !cmp_en[2] |=> !status_bits[0]);

    a_r5_irq_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> ($past(flag_clr) != 3'b000));

    a_r8_batt_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr[0] |=> (!status_bits[5] || !$stable(status_bits[4])));

    a_r8_rail_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr[1] |=> (!status_bits[3] || $rose(status_bits[2])));

    a_r8_chg_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr[2] |=> (!status_bits[1] || !$stable(status_bits[0])));
endmodule

bind stat_irq_core stat_irq_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmp_en     (cmp_en),
    .flag_clr   (flag_clr),
    .status_bits(status_bits),
    .irq        (irq)
);

// File: tb/stat_irq_core_test.sv
module stat_irq_core_test;
    typedef struct {
        int         due;
        logic [5:0] st;
        logic       irq;
        string      tag;
    } exp_t;

    localparam int LAT = 3;   // R10: two sync stages plus the status register

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmp_raw = 3'b000;
    logic [2:0] cmp_en = 3'b000;
    logic [2:0] flag_clr = 3'b000;
    logic [5:0] status_bits;
    logic       irq;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    stat_irq_core uut (
        .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .cmp_en(cmp_en),
        .flag_clr(flag_clr), .status_bits(status_bits), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int k, input logic [5:0] s, input logic i, input string tag);
        exp_t e;
        e.due = cyc + k; e.st = s; e.irq = i; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        flag_clr = m;
        nwait(1);
        flag_clr = 3'b000;
    endtask

    // Monitor: compare each expected item in its due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (e.due != cyc || status_bits !== e.st || irq !== e.irq) begin
                n_bad++;
                $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b (due %0d at %0d)",
                         e.tag, status_bits, irq, e.st, e.irq, e.due, cyc);
            end
        end
    end

    initial begin
        nwait(3);
        push(1, 6'b100000, 1'b1, "R7 R6 power-up without charger");
        nwait(1);
        rst = 1'b0;
        push(1, 6'b100000, 1'b1, "R7 state held after reset release"); nwait(1);

        pulse_clr(3'b001);
        push(0 + 0, 6'b000000, 1'b0, "R8 R5 battery flag cleared");
        nwait(1);

        cmp_raw[0] = 1'b1;
        push(4, 6'b000000, 1'b0, "R4 disabled battery reads 0"); nwait(4);
        cmp_en[0] = 1'b1;
        push(1, 6'b110000, 1'b1, "R4 R1 enable alone counts as change"); nwait(1);
        pulse_clr(3'b001);
        push(0, 6'b010000, 1'b0, "R8 battery clear keeps level");
        nwait(1);

        cmp_raw[0] = 1'b0;
        push(2, 6'b010000, 1'b0, "R10 no change before third edge");
        push(3, 6'b100000, 1'b1, "R1 R10 falling battery sets flag"); nwait(3);
        pulse_clr(3'b001);
        push(0, 6'b000000, 1'b0, "R8 battery cleared");
        nwait(1);

        cmp_en[1] = 1'b1;
        cmp_raw[1] = 1'b1;
        push(LAT, 6'b001100, 1'b1, "R2 rail rising sets flag"); nwait(LAT);
        pulse_clr(3'b101);
        push(0, 6'b001100, 1'b1, "R8 zero clear bit leaves rail flag");
        nwait(1);
        pulse_clr(3'b010);
        push(0, 6'b000100, 1'b0, "R8 rail flag cleared");
        nwait(1);
        cmp_raw[1] = 1'b0;
        push(LAT, 6'b000000, 1'b0, "R2 rail falling does not set"); nwait(LAT);

        cmp_en[2] = 1'b1;
        cmp_raw[2] = 1'b1;
        push(LAT, 6'b000011, 1'b1, "R3 charger rising sets flag"); nwait(LAT);
        pulse_clr(3'b100);
        push(0, 6'b000001, 1'b0, "R8 charger flag cleared");
        nwait(1);
        cmp_raw[2] = 1'b0;
        push(LAT, 6'b000010, 1'b1, "R3 charger falling sets flag"); nwait(LAT);
        pulse_clr(3'b100);
        push(0, 6'b000000, 1'b0, "R8 charger cleared");
        nwait(1);

        // R9: clear strobe in the very cycle of the rail set event
        cmp_raw[1] = 1'b1;
        nwait(LAT - 1);
        flag_clr = 3'b010;
        push(1, 6'b001100, 1'b1, "R9 set beats clear");
        nwait(1);
        flag_clr = 3'b000;
        push(1, 6'b001100, 1'b1, "R9 flag still set after strobe"); nwait(1);
        pulse_clr(3'b010);
        push(0, 6'b000100, 1'b0, "R8 rail cleared after R9");
        nwait(1);

        cmp_raw[0] = 1'b1;
        cmp_raw[2] = 1'b1;
        push(LAT, 6'b110111, 1'b1, "R5 R6 two flags at once"); nwait(LAT);
        pulse_clr(3'b001);
        push(0, 6'b010111, 1'b1, "R5 irq held by charger flag");
        nwait(1);
        pulse_clr(3'b100);
        push(0, 6'b010101, 1'b0, "R5 irq low with no flag");
        nwait(1);

        cmp_en = 3'b000;
        push(1, 6'b100010, 1'b1, "R4 disabling forces 0 and counts as change"); nwait(1);

        rst = 1'b1;
        push(1, 6'b000010, 1'b1, "R7 power-up with charger present"); nwait(1);
        nwait(2);

        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items never compared, expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule